// File: doc/BRIEF.md
# Post-Trigger Conversion Count Gate

This block decides when a residual conversion counter may run, and it ends an acquisition after a programmed number of conversions. Software loads a count N while the gate is closed. A selected start strobe then latches the gate open. From then on, every ADC conversion decrements the counter. When the count runs out, the block closes the gate, raises a one-cycle stop pulse and stays finished until a new acquisition is started.

Two control bits choose the strobe that opens the gate. With the post-mode select at 0, the FIFO half-full event opens it. With post-mode select at 1, which suits counts no larger than half the FIFO, the first conversion opens it when pretriggering is off, and the external trigger opens it when pretriggering is on. An arming bit enables the whole mechanism. While it is low, the gate cannot open and counting is frozen.

Top module: `ptrig_count_gate`

## Requirements
- R1: After synchronous reset, `ctr_gate` is 0, `ctr_value` is 0 and `acq_stop` is 0.
- R2: With `post_sel` = 0, a `fifo_half_stb` pulse opens the gate on the next clock edge, and `conv_stb` and `ext_trig` do not open it.
- R3: With `post_sel` = 1 and `pretrig_en` = 0, a `conv_stb` pulse opens the gate. That opening conversion is not counted.
- R4: With `post_sel` = 1 and `pretrig_en` = 1, an `ext_trig` pulse opens the gate, and `conv_stb` does not open it.
- R5: While `armed` is 0, the gate does not open, and conversions seen with the gate open leave `ctr_value` unchanged.
- R6: Each `conv_stb` seen while the gate is open and `armed` is 1 lowers `ctr_value` by exactly one.
- R7: A counted conversion that finds `ctr_value` at 1 or 0 sets the count to 0. On the same edge it closes the gate and raises `acq_stop`, and `acq_stop` lasts exactly one cycle.
- R8: After a stop, no strobe reopens the gate until `acq_start` is pulsed.
- R9: `load_stb` with the gate closed sets `ctr_value` to `load_val`. With the gate open it is ignored. Apart from loads and counted conversions, `ctr_value` holds its value.
- R10: `acq_start` closes the gate and clears the finished state. It takes priority over a start strobe or a conversion in the same cycle.
- R11: A loaded count of 0 ends the acquisition at the first counted conversion after the gate opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| armed | input | 1 | Enables gate latching and counting |
| post_sel | input | 1 | Start-strobe select: 0 = FIFO half-full, 1 = conversion or trigger |
| pretrig_en | input | 1 | Pretrigger setting; with post_sel = 1 picks the external trigger |
| conv_stb | input | 1 | One-cycle ADC conversion strobe |
| fifo_half_stb | input | 1 | One-cycle FIFO half-full strobe |
| ext_trig | input | 1 | One-cycle external trigger strobe |
| acq_start | input | 1 | Starts a new acquisition: closes the gate, clears finished state |
| load_stb | input | 1 | Load request for the count |
| load_val | input | CNT_W | Count N to load |
| ctr_gate | output | 1 | Counter gate (registered) |
| ctr_value | output | CNT_W | Residual count (registered) |
| acq_stop | output | 1 | One-cycle pulse at terminal count |

## Verification
The bench walks each of the three strobe selections and checks that the strobes that are not selected are refused. A wrong select decode would open the gate on the wrong event. It also checks that the opening conversion is not counted, so a design that counts it would stop one conversion early. Terminal cases include a count of 0 and re-strobing after a stop, which a design without a finished state would restart. It covers loads while the gate is open, conversions with the arming bit low, and `acq_start` arriving in the same cycle as a strobe, where the wrong priority leaves the gate open.

// File: rtl/ptcg_pkg.sv
package ptcg_pkg;

  typedef enum logic [1:0] {
    SRC_FIFO_HALF = 2'd0,
    SRC_CONVERT   = 2'd1,
    SRC_EXT_TRIG  = 2'd2
  } gate_src_e;

  // post-mode 0 -> FIFO half-full; post-mode 1 -> conversion or trigger
  function automatic gate_src_e pick_src(input logic post_sel, input logic pretrig);
    if (!post_sel)   return SRC_FIFO_HALF;
    else if (pretrig) return SRC_EXT_TRIG;
    else             return SRC_CONVERT;
  endfunction

endpackage

// File: rtl/gate_strobe_sel.sv
module gate_strobe_sel
  import ptcg_pkg::*;
(
  input  logic      post_sel,
  input  logic      pretrig_en,
  input  logic      conv_stb,
  input  logic      fifo_half_stb,
  input  logic      ext_trig,
  output gate_src_e src,
  output logic      gate_stb
);

  always_comb begin
    src = pick_src(post_sel, pretrig_en);
    unique case (src)
      SRC_FIFO_HALF: gate_stb = fifo_half_stb;
      SRC_CONVERT:   gate_stb = conv_stb;
      SRC_EXT_TRIG:  gate_stb = ext_trig;
      default:       gate_stb = 1'b0;
    endcase
  end

endmodule

// File: rtl/gate_latch.sv
module gate_latch (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic gate_stb,
  input  logic acq_start,
  input  logic term_evt,
  output logic gate_q,
  output logic done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else if (acq_start) begin
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else if (term_evt) begin
      gate_q <= 1'b0;
      done_q <= 1'b1;
    end else if (!gate_q && !done_q && armed && gate_stb) begin
      gate_q <= 1'b1;
    end
  end

  // R5: gate only opens after a cycle with armed high
  a_r5_open_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(armed));

  // R8: finished state blocks reopening
  a_r8_done_blocks: assert property (@(posedge clk) disable iff (rst)
    (done_q && !acq_start) |=> !gate_q);

  // R10: new acquisition closes the gate
  a_r10_start_closes: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> (!gate_q && !done_q));

endmodule

// File: rtl/residual_ctr.sv
module residual_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_q,
  input  logic             armed,
  input  logic             conv_stb,
  input  logic             acq_start,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tc_q,
  output logic             term_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic count_evt;

  always_comb begin
    count_evt = gate_q && armed && conv_stb && !acq_start;
    term_evt  = count_evt && (cnt_q <= ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= term_evt;
      if (count_evt) begin
        cnt_q <= (cnt_q <= ONE) ? '0 : cnt_q - ONE;
      end else if (load_stb && !gate_q) begin
        cnt_q <= load_val;
      end
    end
  end

  // R6: one step down per counted conversion
  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    (count_evt && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

  // R9: load ignored with the gate open
  a_r9_load_ignored: assert property (@(posedge clk) disable iff (rst)
    (gate_q && load_stb && !count_evt) |=> $stable(cnt_q));

  // R7: stop is a single-cycle pulse
  a_r7_stop_pulse: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q);

endmodule

// File: rtl/ptrig_count_gate.sv
module ptrig_count_gate
  import ptcg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             post_sel,
  input  logic             pretrig_en,
  input  logic             conv_stb,
  input  logic             fifo_half_stb,
  input  logic             ext_trig,
  input  logic             acq_start,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic             ctr_gate,
  output logic [CNT_W-1:0] ctr_value,
  output logic             acq_stop
);

  gate_src_e src;
  logic      gate_stb;
  logic      gate_q;
  logic      done_q;
  logic      term_evt;

  gate_strobe_sel u_sel (
    .post_sel      (post_sel),
    .pretrig_en    (pretrig_en),
    .conv_stb      (conv_stb),
    .fifo_half_stb (fifo_half_stb),
    .ext_trig      (ext_trig),
    .src           (src),
    .gate_stb      (gate_stb)
  );

  gate_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .armed     (armed),
    .gate_stb  (gate_stb),
    .acq_start (acq_start),
    .term_evt  (term_evt),
    .gate_q    (gate_q),
    .done_q    (done_q)
  );

  residual_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .gate_q    (gate_q),
    .armed     (armed),
    .conv_stb  (conv_stb),
    .acq_start (acq_start),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .cnt_q     (ctr_value),
    .tc_q      (acq_stop),
    .term_evt  (term_evt)
  );

  assign ctr_gate = gate_q;

  // R7: stop coincides with a closed gate
  a_r7_stop_closes: assert property (@(posedge clk) disable iff (rst)
    acq_stop |-> !ctr_gate);

  // R5: counting frozen while disarmed
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (ctr_gate && !armed) |=> $stable(ctr_value));

endmodule

// File: tb/ptrig_count_gate_bench.sv
module ptrig_count_gate_bench;

  localparam int CW = 16;

  typedef struct packed {
    logic a, p, r, c, f, e, s, l;
    logic [CW-1:0] val;
    logic eg;
    logic [CW-1:0] ec;
    logic es;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 32;
  // fields: armed post pretrig conv fifo ext start load val | gate cnt stop | req
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,0,0,0,1, 16'd3, 0,16'd3,0, 4'd9},  // R9 load while closed
    '{1,1,0,1,0,0,0,0, 16'd0, 1,16'd3,0, 4'd3},  // R3 conv opens, not counted
    '{1,1,0,0,0,0,0,1, 16'd9, 1,16'd3,0, 4'd9},  // R9 load while open ignored
    '{1,1,0,1,0,0,0,0, 16'd0, 1,16'd2,0, 4'd6},  // R6
    '{1,1,0,0,0,0,0,0, 16'd0, 1,16'd2,0, 4'd9},  // R9 hold
    '{1,1,0,1,0,0,0,0, 16'd0, 1,16'd1,0, 4'd6},  // R6
    '{1,1,0,1,0,0,0,0, 16'd0, 0,16'd0,1, 4'd7},  // R7 terminal
    '{1,1,0,0,0,0,0,0, 16'd0, 0,16'd0,0, 4'd7},  // R7 pulse ends
    '{1,1,0,1,0,0,0,0, 16'd0, 0,16'd0,0, 4'd8},  // R8 no reopen
    '{1,1,1,0,0,0,1,0, 16'd0, 0,16'd0,0, 4'd10}, // R10 start
    '{1,1,1,0,0,0,0,1, 16'd2, 0,16'd2,0, 4'd9},  // R9
    '{1,1,1,1,0,0,0,0, 16'd0, 0,16'd2,0, 4'd4},  // R4 conv refused
    '{1,1,1,0,0,1,0,0, 16'd0, 1,16'd2,0, 4'd4},  // R4 ext opens
    '{1,1,1,1,0,0,0,0, 16'd0, 1,16'd1,0, 4'd6},  // R6
    '{1,1,1,1,0,0,0,0, 16'd0, 0,16'd0,1, 4'd7},  // R7
    '{1,0,0,0,0,0,1,0, 16'd0, 0,16'd0,0, 4'd10}, // R10
    '{1,0,0,0,0,0,0,1, 16'd1, 0,16'd1,0, 4'd9},  // R9
    '{1,0,0,0,0,1,0,0, 16'd0, 0,16'd1,0, 4'd2},  // R2 ext refused
    '{1,0,0,1,0,0,0,0, 16'd0, 0,16'd1,0, 4'd2},  // R2 conv refused
    '{1,0,0,0,1,0,0,0, 16'd0, 1,16'd1,0, 4'd2},  // R2 fifo opens
    '{1,0,0,1,0,0,0,0, 16'd0, 0,16'd0,1, 4'd7},  // R7
    '{0,0,0,0,0,0,1,1, 16'd2, 0,16'd2,0, 4'd10}, // R10 start + load
    '{0,0,0,0,1,0,0,0, 16'd0, 0,16'd2,0, 4'd5},  // R5 disarmed no open
    '{1,0,0,0,1,0,0,0, 16'd0, 1,16'd2,0, 4'd2},  // R2
    '{0,0,0,1,0,0,0,0, 16'd0, 1,16'd2,0, 4'd5},  // R5 frozen
    '{1,0,0,1,0,0,0,0, 16'd0, 1,16'd1,0, 4'd6},  // R6
    '{1,0,0,1,0,0,1,0, 16'd0, 0,16'd1,0, 4'd10}, // R10 start beats conv
    '{1,1,0,0,0,0,0,1, 16'd0, 0,16'd0,0, 4'd11}, // R11 load zero
    '{1,1,0,1,0,0,0,0, 16'd0, 1,16'd0,0, 4'd11}, // R11 open
    '{1,1,0,1,0,0,0,0, 16'd0, 0,16'd0,1, 4'd11}, // R11 ends at once
    '{1,1,0,0,0,0,1,0, 16'd0, 0,16'd0,0, 4'd10}, // R10
    '{1,1,0,1,0,0,1,0, 16'd0, 0,16'd0,0, 4'd10}  // R10 start beats strobe
  };

  logic clk = 0, rst = 1;
  logic armed = 0, post_sel = 0, pretrig_en = 0, conv_stb = 0;
  logic fifo_half_stb = 0, ext_trig = 0, acq_start = 0, load_stb = 0;
  logic [CW-1:0] load_val = '0;
  logic ctr_gate, acq_stop;
  logic [CW-1:0] ctr_value;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ptrig_count_gate #(.CNT_W(CW)) u_ptrig_count_gate (
    .clk(clk), .rst(rst), .armed(armed), .post_sel(post_sel),
    .pretrig_en(pretrig_en), .conv_stb(conv_stb), .fifo_half_stb(fifo_half_stb),
    .ext_trig(ext_trig), .acq_start(acq_start), .load_stb(load_stb),
    .load_val(load_val), .ctr_gate(ctr_gate), .ctr_value(ctr_value),
    .acq_stop(acq_stop)
  );

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    armed = v.a; post_sel = v.p; pretrig_en = v.r; conv_stb = v.c;
    fifo_half_stb = v.f; ext_trig = v.e; acq_start = v.s; load_stb = v.l;
    load_val = v.val;
  endtask

  task automatic idle();
    conv_stb = 0; fifo_half_stb = 0; ext_trig = 0; acq_start = 0; load_stb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 gate", CW'(ctr_gate), '0);
    chk("R1 count", ctr_value, '0);
    chk("R1 stop", CW'(acq_stop), '0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      chk($sformatf("R%0d gate v%0d", VECS[i].req, i), CW'(ctr_gate), CW'(VECS[i].eg));
      chk($sformatf("R%0d count v%0d", VECS[i].req, i), ctr_value, VECS[i].ec);
      chk($sformatf("R%0d stop v%0d", VECS[i].req, i), CW'(acq_stop), CW'(VECS[i].es));
    end
    // R1 reset in the middle of counting
    @(negedge clk); idle(); armed = 1; post_sel = 0; load_stb = 1; load_val = 16'd5;
    @(negedge clk); idle(); fifo_half_stb = 1;
    @(negedge clk); idle(); conv_stb = 1;
    @(negedge clk); idle();
    chk("R6 mid count", ctr_value, 16'd4);
    rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 gate after reset", CW'(ctr_gate), '0);
    chk("R1 count after reset", ctr_value, '0);
    // R9 large load value at the width limit
    @(negedge clk); load_stb = 1; load_val = '1;
    @(negedge clk); idle();
    chk("R9 full-width load", ctr_value, '1);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule